// File: doc/BRIEF.md
# Integer Add Unit with Condition Flags

This block executes the integer addition family of a 32-bit RISC instruction set: immediate forms (plain, upper-shifted, carrying, carrying with record) and register forms (plain, carrying, extended, extended with minus one, extended with zero). It takes a decoded instruction word and the values of its two source registers. It returns the destination value and the destination register index. It also keeps the architectural carry, overflow, sticky summary-overflow and the 4-bit condition field 0 in its own registers. All flags come from one full-width adder with a carry-in. The OE and Rc bits of each instruction select which flags it updates.

Operations arrive on a valid/ready stream and leave on a second valid/ready stream through a single output register. An input is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the output payload holds steady and no new operation is taken. Flags change only on the edge that accepts a legal operation, so the carry an operation reads is the one left by the previous accepted operation. The plain `so_clear` input clears the summary-overflow bit.

Top module: `addu_core`

## Requirements
- R1: `in_ready` is high exactly when `out_valid` is low or `out_ready` is high. While `out_valid` is high and `out_ready` is low, `out_valid`, `out_rd`, `out_dst` and `out_illegal` hold, and the flags do not change.
- R2: Instruction fields (bit 31 is most significant): primary opcode [31:26], destination index [25:21], source A index [20:16], source B index [15:11], OE [10], extended opcode [9:1], Rc [0], immediate [15:0]. `out_dst` returns the destination index of the accepted instruction, one cycle after acceptance.
- R3: Immediate forms sign-extend the immediate to 32 bits. Primary 0x0C adds it to A. Primary 0x0F adds it shifted left by 16. For 0x0C and 0x0F only, a source A index of 0 means the value zero. Primaries 0x0D and 0x0E add the sign-extended immediate to A, whatever the index.
- R4: Under primary 0x1F, the extended opcodes give: 0x10A A+B, 0x00A A+B, 0x08A A+B+carry, 0x0EA A+carry−1, 0x0CA A+carry. The result is modulo 2^32.
- R5: Carry is the carry out of the 33-bit sum, including the carry-in. It is written by 0x0D, 0x0E, 0x00A, 0x08A, 0x0EA and 0x0CA, whatever OE is. It is left unchanged by 0x0C, 0x0F and 0x10A.
- R6: For register forms with OE=1, overflow is written with the signed overflow of the sum: both addends have the same sign and the result sign differs from A. With OE=0, and for all immediate forms, overflow is unchanged.
- R7: Summary-overflow is sticky. `so_clear` clears it first, then an OE=1 operation in the same cycle ORs in its new overflow. Nothing else lowers it.
- R8: Condition field 0 is written when Rc=1 on register forms, and always for primary 0x0E. Bit 3 is result negative, bit 2 is positive and non-zero, bit 1 is zero, and bit 0 is the updated summary-overflow. Otherwise it is unchanged.
- R9: An unknown primary or extended opcode is illegal. So is 0x0EA or 0x0CA with a non-zero source B index. An illegal operation gives `out_illegal`=1 and `out_rd`=0, and changes no flag.
- R10: A synchronous active-low reset clears `out_valid`, the carry, overflow and summary-overflow bits, and condition field 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| so_clear | input | 1 | Clears summary-overflow |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be taken |
| in_instr | input | 32 | Instruction word |
| in_ra | input | 32 | Source A register value |
| in_rb | input | 32 | Source B register value |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes result |
| out_rd | output | 32 | Destination value |
| out_dst | output | 5 | Destination register index |
| out_illegal | output | 1 | Operation was not recognised |
| ca | output | 1 | Carry bit |
| ov | output | 1 | Overflow bit |
| so | output | 1 | Summary-overflow bit |
| cr0 | output | 4 | Condition field 0 |

## Verification
The assertions check on every cycle that the output stays stable under back-pressure, that summary-overflow never falls without `so_clear`, and that a rising overflow always comes with summary-overflow. They also check that condition field 0 never shows more than one sign bit, that an illegal operation leaves the flags unchanged, and that reset clears the state. Only the bench's sweeps show the arithmetic itself. That covers the per-opcode choice of addends and carry-in, the carry and overflow values at the signed and unsigned limits, the literal-zero source A rule, and which flags each OE/Rc combination leaves untouched. The sweeps also cover the carry chained from one operation into the next, and clearing summary-overflow in the same cycle as an overflowing operation.

// File: rtl/addu_pkg.sv
package addu_pkg;
  localparam int INSN_W = 32;
  localparam int IMM_W  = 16;
  localparam int REG_IDX_W = 5;
  localparam int PRI_W  = 6;
  localparam int XO_W   = 9;

  localparam logic [PRI_W-1:0] PRI_ADD_IMM    = 6'h0C;
  localparam logic [PRI_W-1:0] PRI_ADD_IMM_C  = 6'h0D;
  localparam logic [PRI_W-1:0] PRI_ADD_IMM_CR = 6'h0E;
  localparam logic [PRI_W-1:0] PRI_ADD_IMM_HI = 6'h0F;
  localparam logic [PRI_W-1:0] PRI_REG_GROUP  = 6'h1F;

  localparam logic [XO_W-1:0] XO_ADD     = 9'h10A;
  localparam logic [XO_W-1:0] XO_ADD_C   = 9'h00A;
  localparam logic [XO_W-1:0] XO_ADD_EXT = 9'h08A;
  localparam logic [XO_W-1:0] XO_ADD_M1  = 9'h0EA;
  localparam logic [XO_W-1:0] XO_ADD_Z   = 9'h0CA;

  typedef enum logic [2:0] {
    BSEL_REG,
    BSEL_IMM,
    BSEL_IMM_HI,
    BSEL_ONES,
    BSEL_ZERO
  } bsel_e;

  typedef struct packed {
    logic  legal;
    logic  a_zero;
    bsel_e bsel;
    logic  cin_ca;
    logic  wr_ca;
    logic  wr_ov;
    logic  wr_cr;
  } add_ctl_t;
endpackage

// File: rtl/addu_decode.sv
module addu_decode
  import addu_pkg::*;
(
  input  logic [PRI_W-1:0]     pri,
  input  logic [XO_W-1:0]      xo,
  input  logic [REG_IDX_W-1:0] ra_idx,
  input  logic [REG_IDX_W-1:0] rb_idx,
  input  logic                 oe,
  input  logic                 rc,
  output add_ctl_t             ctl
);
  add_ctl_t raw;

  always_comb begin
    raw = '0;
    raw.bsel = BSEL_REG;
    case (pri)
      PRI_ADD_IMM: begin
        raw.legal  = 1'b1;
        raw.a_zero = (ra_idx == '0);
        raw.bsel   = BSEL_IMM;
      end
      PRI_ADD_IMM_HI: begin
        raw.legal  = 1'b1;
        raw.a_zero = (ra_idx == '0);
        raw.bsel   = BSEL_IMM_HI;
      end
      PRI_ADD_IMM_C: begin
        raw.legal = 1'b1;
        raw.bsel  = BSEL_IMM;
        raw.wr_ca = 1'b1;
      end
      PRI_ADD_IMM_CR: begin
        raw.legal = 1'b1;
        raw.bsel  = BSEL_IMM;
        raw.wr_ca = 1'b1;
        raw.wr_cr = 1'b1;
      end
      PRI_REG_GROUP: begin
        raw.wr_ov = oe;
        raw.wr_cr = rc;
        case (xo)
          XO_ADD: begin
            raw.legal = 1'b1;
          end
          XO_ADD_C: begin
            raw.legal = 1'b1;
            raw.wr_ca = 1'b1;
          end
          XO_ADD_EXT: begin
            raw.legal  = 1'b1;
            raw.wr_ca  = 1'b1;
            raw.cin_ca = 1'b1;
          end
          XO_ADD_M1: begin
            raw.legal  = (rb_idx == '0);
            raw.bsel   = BSEL_ONES;
            raw.wr_ca  = 1'b1;
            raw.cin_ca = 1'b1;
          end
          XO_ADD_Z: begin
            raw.legal  = (rb_idx == '0);
            raw.bsel   = BSEL_ZERO;
            raw.wr_ca  = 1'b1;
            raw.cin_ca = 1'b1;
          end
          default: raw.legal = 1'b0;
        endcase
      end
      default: raw.legal = 1'b0;
    endcase
  end

  // an illegal operation carries no write enables at all
  assign ctl = raw.legal ? raw : '0;
endmodule

// File: rtl/addu_sum.sv
module addu_sum
  import addu_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0]    a_val,
  input  logic [DW-1:0]    b_val,
  input  logic [IMM_W-1:0] imm,
  input  logic             a_zero,
  input  bsel_e            bsel,
  input  logic             cin_en,
  input  logic             ca_cur,
  output logic [DW-1:0]    sum,
  output logic             carry,
  output logic             ovf
);
  localparam int EXT_W = DW - IMM_W;

  logic [DW-1:0] imm_ext;
  logic [DW-1:0] a_op;
  logic [DW-1:0] b_op;
  logic          cin;
  logic [DW:0]   full;

  assign imm_ext = {{EXT_W{imm[IMM_W-1]}}, imm};
  assign a_op    = a_zero ? '0 : a_val;
  assign cin     = cin_en & ca_cur;

  always_comb begin
    case (bsel)
      BSEL_IMM:    b_op = imm_ext;
      BSEL_IMM_HI: b_op = imm_ext << IMM_W;
      BSEL_ONES:   b_op = '1;
      BSEL_ZERO:   b_op = '0;
      default:     b_op = b_val;
    endcase
  end

  // one adder: 33rd bit is carry, sign bits give signed overflow
  assign full  = {1'b0, a_op} + {1'b0, b_op} + {{DW{1'b0}}, cin};
  assign sum   = full[DW-1:0];
  assign carry = full[DW];
  assign ovf   = ~(a_op[DW-1] ^ b_op[DW-1]) & (a_op[DW-1] ^ sum[DW-1]);
endmodule

// File: rtl/addu_flags.sv
module addu_flags #(
  parameter int DW = 32,
  parameter int CRW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          upd,
  input  logic          so_clear,
  input  logic          wr_ca,
  input  logic          wr_ov,
  input  logic          wr_cr,
  input  logic [DW-1:0] sum,
  input  logic          carry,
  input  logic          ovf,
  output logic          ca,
  output logic          ov,
  output logic          so,
  output logic [CRW-1:0] cr0
);
  logic so_base;
  logic so_next;
  logic res_neg;
  logic res_zero;

  assign so_base  = so & ~so_clear;
  assign so_next  = (upd && wr_ov) ? (so_base | ovf) : so_base;
  assign res_neg  = sum[DW-1];
  assign res_zero = (sum == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ca  <= 1'b0;
      ov  <= 1'b0;
      so  <= 1'b0;
      cr0 <= '0;
    end else begin
      so <= so_next;
      if (upd && wr_ca) ca <= carry;
      if (upd && wr_ov) ov <= ovf;
      if (upd && wr_cr) cr0 <= {res_neg, ~res_neg & ~res_zero, res_zero, so_next};
    end
  end
endmodule

// File: rtl/addu_core.sv
module addu_core
  import addu_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 so_clear,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [INSN_W-1:0]    in_instr,
  input  logic [DW-1:0]        in_ra,
  input  logic [DW-1:0]        in_rb,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [DW-1:0]        out_rd,
  output logic [REG_IDX_W-1:0] out_dst,
  output logic                 out_illegal,
  output logic                 ca,
  output logic                 ov,
  output logic                 so,
  output logic [3:0]           cr0
);
  localparam int CRW = 4;

  add_ctl_t      ctl;
  logic [DW-1:0] sum;
  logic          carry;
  logic          ovf;
  logic          accept;

  addu_decode u_dec (
    .pri    (in_instr[31:26]),
    .xo     (in_instr[9:1]),
    .ra_idx (in_instr[20:16]),
    .rb_idx (in_instr[15:11]),
    .oe     (in_instr[10]),
    .rc     (in_instr[0]),
    .ctl    (ctl)
  );

  addu_sum #(.DW(DW)) u_sum (
    .a_val  (in_ra),
    .b_val  (in_rb),
    .imm    (in_instr[IMM_W-1:0]),
    .a_zero (ctl.a_zero),
    .bsel   (ctl.bsel),
    .cin_en (ctl.cin_ca),
    .ca_cur (ca),
    .sum    (sum),
    .carry  (carry),
    .ovf    (ovf)
  );

  assign in_ready = ~out_valid | out_ready;
  assign accept   = in_valid & in_ready;

  addu_flags #(.DW(DW), .CRW(CRW)) u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .upd      (accept & ctl.legal),
    .so_clear (so_clear),
    .wr_ca    (ctl.wr_ca),
    .wr_ov    (ctl.wr_ov),
    .wr_cr    (ctl.wr_cr),
    .sum      (sum),
    .carry    (carry),
    .ovf      (ovf),
    .ca       (ca),
    .ov       (ov),
    .so       (so),
    .cr0      (cr0)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_rd      <= '0;
      out_dst     <= '0;
      out_illegal <= 1'b0;
    end else if (accept) begin
      out_valid   <= 1'b1;
      out_rd      <= ctl.legal ? sum : '0;
      out_dst     <= in_instr[25:21];
      out_illegal <= ~ctl.legal;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/addu_core_chk.sv
module addu_core_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          so_clear,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_rd,
  input logic          out_illegal,
  input logic          ca,
  input logic          ov,
  input logic          so,
  input logic [3:0]    cr0
);
  logic rst_d;

  always_ff @(posedge clk) rst_d <= ~rst_n;

  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_rd) && $stable(out_illegal)));

  assert_illegal_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (!out_illegal || ($stable(ca) && $stable(ov) && $stable(cr0))));

  assert_so_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (so && !so_clear) |=> so);

  assert_ov_sets_so_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ov) |-> so);

  assert_cr0_sign_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cr0[3:1]));

  always @(posedge clk) begin
    if (rst_d) begin
      assert_reset_clear_R10: assert (!out_valid && !ca && !ov && !so && cr0 == 4'h0)
        else $error("state not cleared after reset");
    end
  end
endmodule

bind addu_core addu_core_chk #(.DW(DW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .so_clear    (so_clear),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_rd      (out_rd),
  .out_illegal (out_illegal),
  .ca          (ca),
  .ov          (ov),
  .so          (so),
  .cr0         (cr0)
);

// File: tb/addu_core_tb.sv
module addu_core_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        so_clear = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_instr = '0;
  logic [31:0] in_ra = '0;
  logic [31:0] in_rb = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_rd;
  logic [4:0]  out_dst;
  logic        out_illegal;
  logic        ca, ov, so;
  logic [3:0]  cr0;

  int checks = 0;
  int errors = 0;

  logic        m_ca = 0, m_ov = 0, m_so = 0;
  logic [3:0]  m_cr0 = '0;
  logic [31:0] exp_rd;
  logic [4:0]  exp_dst;
  logic        exp_ill;
  string       rd_req;
  logic [31:0] vals [10];

  always #2 clk = ~clk;

  addu_core u_dut (
    .clk(clk), .rst_n(rst_n), .so_clear(so_clear),
    .in_valid(in_valid), .in_ready(in_ready), .in_instr(in_instr),
    .in_ra(in_ra), .in_rb(in_rb), .out_valid(out_valid), .out_ready(out_ready),
    .out_rd(out_rd), .out_dst(out_dst), .out_illegal(out_illegal),
    .ca(ca), .ov(ov), .so(so), .cr0(cr0)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_imm(input logic [5:0] pri, input logic [4:0] rd,
                                         input logic [4:0] ra, input logic [15:0] imm);
    return {pri, rd, ra, imm};
  endfunction

  function automatic logic [31:0] mk_reg(input logic [8:0] xo, input logic [4:0] rd, input logic [4:0] ra,
                                         input logic [4:0] rb, input logic oe, input logic rc);
    return {6'h1F, rd, ra, rb, oe, xo, rc};
  endfunction

  // reference model built from the requirements; updates m_* state
  task automatic model_step(input logic [31:0] insn, input logic [31:0] a, input logic [31:0] b);
    logic [5:0]  pri;
    logic [8:0]  xo;
    logic        oe, rc, legal, wca, wov, wcr, cin, cout, ovf, neg, zer;
    logic [31:0] x, y, r, simm;
    pri = insn[31:26]; xo = insn[9:1]; oe = insn[10]; rc = insn[0];
    simm = {{16{insn[15]}}, insn[15:0]};
    legal = 1; wca = 0; wov = 0; wcr = 0; cin = 0; x = a; y = b;
    rd_req = "R4";
    case (pri)
      6'h0C: begin rd_req = "R3"; if (insn[20:16] == 0) x = 0; y = simm; end
      6'h0F: begin rd_req = "R3"; if (insn[20:16] == 0) x = 0; y = {insn[15:0], 16'h0}; end
      6'h0D: begin rd_req = "R3"; y = simm; wca = 1; end
      6'h0E: begin rd_req = "R3"; y = simm; wca = 1; wcr = 1; end
      6'h1F: begin
        wov = oe; wcr = rc;
        case (xo)
          9'h10A: ;
          9'h00A: wca = 1;
          9'h08A: begin wca = 1; cin = m_ca; end
          9'h0EA: begin legal = (insn[15:11] == 0); wca = 1; cin = m_ca; y = 32'hFFFF_FFFF; end
          9'h0CA: begin legal = (insn[15:11] == 0); wca = 1; cin = m_ca; y = 32'h0; end
          default: legal = 0;
        endcase
      end
      default: legal = 0;
    endcase
    r = x + y + {31'b0, cin};
    cout = (r < x) || (cin && r == x);
    ovf = (x[31] == y[31]) && (r[31] != x[31]);
    exp_dst = insn[25:21];
    if (!legal) begin
      rd_req = "R9"; exp_rd = 0; exp_ill = 1;
    end else begin
      exp_rd = r; exp_ill = 0;
      if (wov) begin m_ov = ovf; m_so = m_so | ovf; end
      if (wca) m_ca = cout;
      if (wcr) begin
        neg = r[31]; zer = (r == 0);
        m_cr0 = {neg, !neg && !zer, zer, m_so};
      end
    end
  endtask

  task automatic compare_all();
    chk("R1", "out_valid", {31'b0, out_valid}, 32'd1);
    chk(rd_req, "result", out_rd, exp_rd);
    chk("R9", "illegal", {31'b0, out_illegal}, {31'b0, exp_ill});
    chk("R2", "dst", {27'b0, out_dst}, {27'b0, exp_dst});
    chk("R5", "carry", {31'b0, ca}, {31'b0, m_ca});
    chk("R6", "overflow", {31'b0, ov}, {31'b0, m_ov});
    chk("R7", "summary", {31'b0, so}, {31'b0, m_so});
    chk("R8", "cr0", {28'b0, cr0}, {28'b0, m_cr0});
  endtask

  task automatic run_op(input logic [31:0] insn, input logic [31:0] a, input logic [31:0] b, input logic clr);
    @(negedge clk);
    in_instr = insn; in_ra = a; in_rb = b; in_valid = 1; so_clear = clr;
    @(posedge clk);
    @(negedge clk);
    in_valid = 0; so_clear = 0;
    if (clr) m_so = 0;
    model_step(insn, a, b);
    compare_all();
  endtask

  task automatic clear_so();
    @(negedge clk);
    so_clear = 1;
    @(posedge clk);
    @(negedge clk);
    so_clear = 0;
    m_so = 0;
    chk("R7", "so after clear", {31'b0, so}, 32'd0);
    chk("R6", "ov kept on clear", {31'b0, ov}, {31'b0, m_ov});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] insn;
    logic [31:0] a, b;
    vals[0] = 32'h0000_0000; vals[1] = 32'h0000_0001; vals[2] = 32'h7FFF_FFFF;
    vals[3] = 32'h8000_0000; vals[4] = 32'hFFFF_FFFF; vals[5] = 32'hFFFF_FFFE;
    vals[6] = 32'h1234_5678; vals[7] = 32'h8000_0001; vals[8] = 32'h0000_FFFF;
    vals[9] = 32'h7FFF_0000;

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10: reset state
    chk("R10", "out_valid", {31'b0, out_valid}, 32'd0);
    chk("R10", "flags", {28'b0, ca, ov, so, 1'b0}, 32'd0);
    chk("R10", "cr0", {28'b0, cr0}, 32'd0);
    chk("R1", "in_ready idle", {31'b0, in_ready}, 32'd1);

    // sweep of every opcode over corner operands and OE/Rc/literal-zero choices
    for (int op = 0; op < 9; op++) begin
      for (int i = 0; i < 10; i++) begin
        for (int j = 0; j < 10; j++) begin
          for (int k = 0; k < 4; k++) begin
            a = vals[i]; b = vals[j];
            case (op)
              0: insn = mk_imm(6'h0C, 5'd3, k[0] ? 5'd0 : 5'd4, b[15:0]);
              1: insn = mk_imm(6'h0F, 5'd3, k[0] ? 5'd0 : 5'd4, b[15:0]);
              2: insn = mk_imm(6'h0D, 5'd7, k[0] ? 5'd0 : 5'd4, b[15:0]);
              3: insn = mk_imm(6'h0E, 5'd7, k[0] ? 5'd0 : 5'd4, b[15:0]);
              4: insn = mk_reg(9'h10A, 5'd9, 5'd1, 5'd2, k[1], k[0]);
              5: insn = mk_reg(9'h00A, 5'd9, 5'd1, 5'd2, k[1], k[0]);
              6: insn = mk_reg(9'h08A, 5'd9, 5'd1, 5'd2, k[1], k[0]);
              7: insn = mk_reg(9'h0EA, 5'd9, 5'd1, 5'd0, k[1], k[0]);
              default: insn = mk_reg(9'h0CA, 5'd9, 5'd1, 5'd0, k[1], k[0]);
            endcase
            run_op(insn, a, b, 1'b0);
            if (((i + j + k) % 11) == 0) clear_so();
          end
        end
      end
    end

    // R9: illegal encodings leave flags as they were
    run_op(mk_reg(9'h10A, 5'd1, 5'd1, 5'd2, 1'b1, 1'b1), 32'h7FFF_FFFF, 32'h1, 1'b0);
    run_op({6'h20, 26'h3FF_FFFF}, 32'h1, 32'h1, 1'b0);
    run_op(mk_reg(9'h1FF, 5'd2, 5'd1, 5'd2, 1'b1, 1'b1), 32'hFFFF_FFFF, 32'h1, 1'b0);
    run_op(mk_reg(9'h0EA, 5'd2, 5'd1, 5'd3, 1'b1, 1'b1), 32'h0, 32'h0, 1'b0);
    run_op(mk_reg(9'h0CA, 5'd2, 5'd1, 5'd1, 1'b0, 1'b1), 32'h5, 32'h0, 1'b0);

    // R7: clear and an overflowing OE operation in the same cycle
    run_op(mk_reg(9'h10A, 5'd1, 5'd1, 5'd2, 1'b1, 1'b1), 32'h7FFF_FFFF, 32'h1, 1'b1);
    run_op(mk_reg(9'h10A, 5'd1, 5'd1, 5'd2, 1'b1, 1'b1), 32'h1, 32'h1, 1'b1);
    run_op(mk_reg(9'h10A, 5'd1, 5'd1, 5'd2, 1'b0, 1'b1), 32'h7FFF_FFFF, 32'h1, 1'b0);

    // R1: back-pressure holds the result and blocks the next operation
    @(negedge clk);
    @(negedge clk);
    out_ready = 0;
    in_instr = mk_reg(9'h10A, 5'd11, 5'd1, 5'd2, 1'b0, 1'b0);
    in_ra = 32'h0000_0010; in_rb = 32'h0000_0020; in_valid = 1;
    @(posedge clk);
    @(negedge clk);
    model_step(in_instr, in_ra, in_rb);
    in_instr = mk_reg(9'h00A, 5'd12, 5'd1, 5'd2, 1'b0, 1'b1);
    in_ra = 32'hFFFF_FFFF; in_rb = 32'h0000_0001;
    chk("R1", "first result", out_rd, exp_rd);
    chk("R1", "in_ready stalled", {31'b0, in_ready}, 32'd0);
    @(posedge clk);
    @(negedge clk);
    chk("R1", "held result", out_rd, exp_rd);
    chk("R1", "held dst", {27'b0, out_dst}, 32'd11);
    chk("R1", "held valid", {31'b0, out_valid}, 32'd1);
    chk("R1", "carry not taken", {31'b0, ca}, {31'b0, m_ca});
    out_ready = 1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 0;
    model_step(in_instr, in_ra, in_rb);
    compare_all();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule